// File: doc/BRIEF.md
# Parallel Multi-Character Signature Matcher

This block scans a byte stream for a fixed set of signatures. The signatures are given as elaboration-time parameters and are compared by hard-wired comparators, so they cannot be changed while the block runs. Each clock carries `LANES` bytes of the stream. Lane 0 holds the earliest byte. A signature may begin at any lane of any word, so an occurrence can sit inside one word or span a word boundary.

Each signature is a chain of elements, one element per character. An element is active when its character comparator hits and the element before it was active one byte earlier. The first element has no predecessor and only needs its own comparator. The state of the chain after the last lane is kept in a register and feeds lane 0 of the next valid word. When the last element of a signature becomes active, the signature's match bit is set in a registered output for one cycle. A clear input discards all carried partial matches, for use at a packet boundary.

Top module: `sigm_match_top`

## Requirements
- R1: `match_o` is registered. Bit s is high for exactly the one cycle after a valid word in which signature s completed at any lane. After a cycle with `in_valid` low, `match_o` is all zero.
- R2: A signature that lies entirely within one word is detected at whatever lane it starts.
- R3: A signature whose characters span two consecutive valid words is detected. The partial match carried out of lane `LANES-1` continues into lane 0 of the next word.
- R4: Repeated characters in a signature (for example "144") are matched, including when the stream repeats a leading character ("1144").
- R5: Cycles with `in_valid` low neither advance nor drop carried partial matches. A signature broken only by idle cycles is still detected.
- R6: When `in_clear` is high, all carried partial matches are discarded. If `in_valid` is high in the same cycle, that word is matched starting from an empty state.
- R7: Occurrences that overlap (for example "ABAB" inside "ABABAB") are each detected. Two completions of one signature in the same word produce a single set bit.
- R8: After reset, `match_o` is zero and no partial match is carried.
- R9: Different signatures completing in the same word each set their own bit of `match_o` (bit s for signature s) in the same cycle.
- R10: Byte order within a word is significant. Lane l (bits `[8*l+7:8*l]` of `in_data`) comes before lane l+1, so a word holding a signature's characters in reverse order gives no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | `in_data` holds a stream word this cycle |
| in_clear | input | 1 | Discard carried partial matches (packet boundary) |
| in_data | input | 8*LANES | Stream bytes; lane 0 in bits 7:0 is earliest |
| match_o | output | NSIG | One registered match pulse bit per signature |

## Verification
The assertions assume that `in_valid` and `in_clear` are always known levels. They also assume that the bytes in `in_data` matter only while `in_valid` is high. Outside a valid word, only the carry register and the output are expected to react, and only to `in_clear`.

The stimulus changes inputs only on the falling clock edge. It drives every word as exactly `LANES` defined bytes and pads short strings with a filler character that occurs in no signature. It keeps `in_clear` low except in the scenarios written to exercise it.

// File: rtl/sigm_pkg.sv
package sigm_pkg;
   localparam int unsigned CHAR_W = 8;
   localparam int unsigned LEN_W  = 8;
endpackage

// File: rtl/sigm_elem_cmp.sv
module sigm_elem_cmp
   import sigm_pkg::*;
#(
   parameter int unsigned NSIG   = 4,
   parameter int unsigned MAXLEN = 4,
   parameter logic [NSIG*MAXLEN*CHAR_W-1:0] SIG_BYTES = '0,
   parameter logic [NSIG*LEN_W-1:0]         SIG_LEN   = '0
) (
   input  logic [CHAR_W-1:0]      ch,
   output logic [NSIG*MAXLEN-1:0] hit
);
   for (genvar s = 0; s < NSIG; s++) begin : g_sig
      localparam int unsigned SLEN = int'(SIG_LEN[s*LEN_W +: LEN_W]);
      for (genvar k = 0; k < MAXLEN; k++) begin : g_elem
         if (k < SLEN) begin : g_used
            localparam logic [CHAR_W-1:0] REF =
               SIG_BYTES[(s*MAXLEN+k)*CHAR_W +: CHAR_W];
            assign hit[s*MAXLEN+k] = (ch == REF);
         end else begin : g_unused
            assign hit[s*MAXLEN+k] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/sigm_sig_chain.sv
module sigm_sig_chain #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned MAXLEN = 4,
   parameter int unsigned SLEN   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      valid,
   input  logic                      clear,
   input  logic [LANES*MAXLEN-1:0]   hit,
   output logic                      found
);
   logic [MAXLEN-1:0]             carry_q;
   logic [LANES-1:0][MAXLEN-1:0]  st;

   always_comb begin
      logic [MAXLEN-1:0] prev;
      prev  = clear ? '0 : carry_q;
      found = 1'b0;
      for (int l = 0; l < LANES; l++) begin
         for (int k = 0; k < MAXLEN; k++) begin
            if (k == 0) st[l][k] = hit[l*MAXLEN+k];
            else        st[l][k] = hit[l*MAXLEN+k] & prev[k-1];
         end
         prev  = st[l];
         found = found | st[l][SLEN-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      carry_q <= '0;
      else if (valid)  carry_q <= st[LANES-1];
      else if (clear)  carry_q <= '0;
   end

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !valid) |=> (carry_q == '0));                  // R6
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && !clear) |=> $stable(carry_q));                 // R5
   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (carry_q == '0));                        // R8
endmodule

// File: rtl/sigm_match_top.sv
module sigm_match_top
   import sigm_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned NSIG   = 4,
   parameter int unsigned MAXLEN = 4,
   parameter logic [NSIG*MAXLEN*CHAR_W-1:0] SIG_BYTES =
      {8'h42, 8'h41, 8'h42, 8'h41,
       8'h00, 8'h34, 8'h34, 8'h31,
       8'h00, 8'h52, 8'h41, 8'h42,
       8'h00, 8'h4F, 8'h4F, 8'h46},
   parameter logic [NSIG*LEN_W-1:0] SIG_LEN = {8'd4, 8'd3, 8'd3, 8'd3}
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_clear,
   input  logic [LANES*CHAR_W-1:0] in_data,
   output logic [NSIG-1:0]         match_o
);
   localparam int unsigned HIT_W = NSIG*MAXLEN;

   if (LANES < 1)  begin : g_bad_lanes  $error("LANES must be at least 1");  end
   if (NSIG < 1)   begin : g_bad_nsig   $error("NSIG must be at least 1");   end
   if (MAXLEN < 1) begin : g_bad_maxlen $error("MAXLEN must be at least 1"); end

   logic [LANES-1:0][HIT_W-1:0] lane_hit;
   logic [NSIG-1:0]             found;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      sigm_elem_cmp #(
         .NSIG(NSIG), .MAXLEN(MAXLEN),
         .SIG_BYTES(SIG_BYTES), .SIG_LEN(SIG_LEN)
      ) u_cmp (
         .ch  (in_data[l*CHAR_W +: CHAR_W]),
         .hit (lane_hit[l])
      );
   end

   for (genvar s = 0; s < NSIG; s++) begin : g_sig
      localparam int unsigned SLEN = int'(SIG_LEN[s*LEN_W +: LEN_W]);
      if (SLEN < 1 || SLEN > MAXLEN) begin : g_bad_len
         $error("signature length out of range");
      end
      logic [LANES*MAXLEN-1:0] sig_hit;
      for (genvar l = 0; l < LANES; l++) begin : g_pick
         assign sig_hit[l*MAXLEN +: MAXLEN] = lane_hit[l][s*MAXLEN +: MAXLEN];
      end
      sigm_sig_chain #(
         .LANES(LANES), .MAXLEN(MAXLEN),
         .SLEN((SLEN < 1 || SLEN > MAXLEN) ? 1 : SLEN)
      ) u_chain (
         .clk   (clk),
         .rst_n (rst_n),
         .valid (in_valid),
         .clear (in_clear),
         .hit   (sig_hit),
         .found (found[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_o <= '0;
      else        match_o <= in_valid ? found : '0;
   end

   AST_IDLE_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (match_o == '0));                           // R1
   AST_MATCH_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (|match_o) |-> $past(in_valid));                          // R1
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (match_o == '0));                        // R8
endmodule

// File: tb/tb_sigm_match_top.sv
`timescale 1ns/1ps
module tb_sigm_match_top;
   localparam int LANES = 4;
   localparam int NSIG = 4;
   localparam int MAXLEN = 4;
   localparam logic [NSIG*MAXLEN*8-1:0] SIGB =
      {"B","A","B","A", 8'h00,"4","4","1", 8'h00,"R","A","B", 8'h00,"O","O","F"};
   localparam logic [NSIG*8-1:0] SIGL = {8'd4, 8'd3, 8'd3, 8'd3};

   string sigs[NSIG] = '{"FOO", "BAR", "144", "ABAB"};

   logic clk = 0, rst_n = 0, in_valid = 0, in_clear = 0;
   logic [LANES*8-1:0] in_data = '0;
   logic [NSIG-1:0] match_o;

   always #5 clk = ~clk;

   sigm_match_top #(.LANES(LANES), .NSIG(NSIG), .MAXLEN(MAXLEN),
                    .SIG_BYTES(SIGB), .SIG_LEN(SIGL)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_clear(in_clear),
      .in_data(in_data), .match_o(match_o));

   int total = 0, bad = 0;
   logic [NSIG-1:0] exp_q[$];
   string tag_q[$];
   byte hist[$];

   task automatic check(input string tag, input logic [NSIG-1:0] act, input logic [NSIG-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: match_o actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic send(input string w, input bit clr, input string tag);
      logic [NSIG-1:0] e = '0;
      @(negedge clk);
      if (clr) hist.delete();
      for (int l = 0; l < LANES; l++) begin
         byte c = (l < w.len()) ? w[l] : "Z";
         in_data[l*8 +: 8] = c;
         hist.push_back(c);
         for (int s = 0; s < NSIG; s++) begin
            int L = sigs[s].len();
            if (hist.size() >= L) begin
               bit ok = 1;
               for (int i = 0; i < L; i++)
                  if (hist[hist.size()-L+i] != sigs[s][i]) ok = 0;
               if (ok) e[s] = 1'b1;
            end
         end
         while (hist.size() > MAXLEN) void'(hist.pop_front());
      end
      in_valid = 1; in_clear = clr;
      exp_q.push_back(e); tag_q.push_back(tag);
   endtask

   task automatic idle(input bit clr, input string tag);
      @(negedge clk);
      if (clr) hist.delete();
      in_valid = 0; in_clear = clr; in_data = '0;
      exp_q.push_back('0); tag_q.push_back(tag);
   endtask

   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) check(tag_q.pop_front(), match_o, exp_q.pop_front());
   end

   bit done = 0;
   initial begin
      #2000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset", match_o, '0);
      rst_n = 1;
      @(negedge clk);
      check("R8 after release", match_o, '0);
      send("OOZZ", 0, "R8 no carry after reset");
      send("AFOO", 0, "R2 FOO in word");
      send("BARC", 0, "R2 BAR in word");
      idle(0, "R1 pulse ends");
      send("ZZFO", 0, "R3 partial");
      send("OBAR", 0, "R3 R9 straddle and in-word");
      send("1144", 0, "R4 repeated chars");
      send("ZZ14", 0, "R4 partial");
      send("4ZZZ", 0, "R3 R4 straddle repeat");
      send("ZZZF", 0, "R5 partial");
      idle(0, "R5 idle");
      idle(0, "R5 idle");
      send("OOZZ", 0, "R5 resumes after idle");
      send("ZZFO", 0, "R6 partial");
      send("OZZZ", 1, "R6 clear with valid");
      send("ZZZF", 0, "R6 partial");
      idle(1, "R6 clear while idle");
      send("OOZZ", 0, "R6 no match after clear");
      send("ABAB", 0, "R7 first");
      send("ABAB", 0, "R7 overlap twice");
      send("OOFZ", 0, "R10 reversed order");
      send("ZFOO", 0, "R1 match");
      idle(0, "R1 idle after match");
      repeat (3) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule